// File: doc/BRIEF.md
# Two-Road Intersection Light Controller

This block sequences the signal lights of a crossing between two roads, called road A and road B. Each road has a vehicle sensor that reads 1 while traffic waits or flows on that road. Each road gets a 2-bit light code. A Moore sequencer keeps road A green while its sensor reports traffic. When road A goes quiet, the sequencer gives road A one yellow cycle and then turns road B green. Road B stays green while its sensor reports traffic. When road B goes quiet, road B gets one yellow cycle and road A turns green again.

A second small state machine holds a festival (parade) flag. A one-cycle pulse on the enter input sets the flag, and a pulse on the leave input clears it. While the flag is set, the sequencer will not leave the road-B-green state, whatever road B's sensor reports. If the flag is set while the lights are in another phase, the normal sequence runs on until road B is green and then stops there. Reset is synchronous and active low.

Top module: `xroad_light_ctrl`

## Requirements
- R1: While rst_n is 0 at a clock edge, the sequencer goes to the A-green phase and the festival flag clears. After that edge light_a = 00 (green) and light_b = 10 (red).
- R2: The light codes are green = 00, yellow = 01 and red = 10. The code 11 never appears on light_a or light_b.
- R3: In the A-green phase (light_a=00, light_b=10), the lights stay unchanged while sense_a = 1. When sense_a = 0, the next phase is A-yellow.
- R4: The A-yellow phase (light_a=01, light_b=10) lasts exactly one cycle and is always followed by B-green.
- R5: In the B-green phase (light_a=10, light_b=00), the lights stay unchanged while sense_b = 1 or the festival flag is set. Otherwise the next phase is B-yellow.
- R6: The B-yellow phase (light_a=10, light_b=01) lasts exactly one cycle and is always followed by A-green.
- R7: festival_on goes to 1 one cycle after fest_enter = 1 and goes to 0 one cycle after fest_leave = 1. If both are 1 in the same cycle, fest_leave wins.
- R8: If the festival flag is set while the lights are outside B-green, the normal sequence continues until B-green is reached. The lights then hold at B-green until the flag clears.
- R9: Road A and road B are never both non-red in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sense_a | input | 1 | Traffic present on road A |
| sense_b | input | 1 | Traffic present on road B |
| fest_enter | input | 1 | Request to enter festival mode |
| fest_leave | input | 1 | Request to leave festival mode (wins over enter) |
| light_a | output | 2 | Road A light code: 00 green, 01 yellow, 10 red |
| light_b | output | 2 | Road B light code: 00 green, 01 yellow, 10 red |
| festival_on | output | 1 | Festival flag state |

## Verification
Some properties are checked by assertions on every cycle:
- the light codes stay legal and the two roads are never both non-red;
- each yellow phase lasts one cycle and moves to the right next phase;
- the sequencer holds at A-green and at B-green under the right inputs;
- the flag sets, clears and gives fest_leave priority as specified.

Other behaviour can only be shown by the bench scenarios, which compare against a behavioural model on every clock:
- a full light cycle;
- a festival request made while the lights are in another phase, which must travel on until B-green is reached;
- the release of the hold when fest_leave is given while sense_b is still active.

// File: rtl/xroad_pkg.sv
// Shared types for the intersection light controller.
// Assumes a binary two-bit phase code whose order is the sequence order.
package xroad_pkg;
    localparam int LIGHT_W = 2;
    localparam int PHASE_W = 2;

    typedef enum logic [LIGHT_W-1:0] {
        LT_GREEN  = 2'b00,
        LT_YELLOW = 2'b01,
        LT_RED    = 2'b10
    } light_t;

    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_t;
endpackage

// File: rtl/xroad_fest_mode.sv
// Festival-mode flag machine: one bit that sets on enter and clears on leave.
// Assumes single-clock synchronous use; leave wins when both are requested.
module xroad_fest_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic leave_req,
    output logic active
);
    // Flag register: clear on reset or leave, set on enter, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         active <= 1'b0;
        else if (leave_req) active <= 1'b0;
        else if (enter_req) active <= 1'b1;
    end

    a_r7_leave_wins: assert property (@(posedge clk) disable iff (!rst_n)
        leave_req |=> !active);
    a_r7_enter_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_req && !leave_req) |=> active);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enter_req && !leave_req) |=> $stable(active));
endmodule

// File: rtl/xroad_sequencer.sv
// Moore phase sequencer: A green -> A yellow -> B green -> B yellow -> A green.
// Holds at A green while road A is busy, and at B green while road B is busy
// or the hold input is set. Assumes synchronous active-low reset.
module xroad_sequencer
    import xroad_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   busy_a,
    input  logic   busy_b,
    input  logic   hold_b,
    output phase_t phase
);
    phase_t phase_nx;

    // Next-phase selection from the current phase and the sensors.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_A_GO:   if (!busy_a) phase_nx = PH_A_WARN;
            PH_A_WARN: phase_nx = PH_B_GO;
            PH_B_GO:   if (!busy_b && !hold_b) phase_nx = PH_B_WARN;
            PH_B_WARN: phase_nx = PH_A_GO;
            default:   phase_nx = PH_A_GO;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_A_GO;
        else        phase <= phase_nx;
    end

    a_r4_a_warn_once: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_A_WARN |=> phase == PH_B_GO);
    a_r6_b_warn_once: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_B_WARN |=> phase == PH_A_GO);
    a_r3_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_A_GO && busy_a) |=> phase == PH_A_GO);
    a_r5_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_B_GO && (busy_b || hold_b)) |=> phase == PH_B_GO);
endmodule

// File: rtl/xroad_light_decode.sv
// Moore output decode: maps the phase code to one light code per road.
// Assumes the phase codes defined in xroad_pkg.
module xroad_light_decode
    import xroad_pkg::*;
(
    input  phase_t phase,
    output light_t lamp_a,
    output light_t lamp_b
);
    // Light lookup by phase.
    always_comb begin
        unique case (phase)
            PH_A_GO:   begin lamp_a = LT_GREEN;  lamp_b = LT_RED;    end
            PH_A_WARN: begin lamp_a = LT_YELLOW; lamp_b = LT_RED;    end
            PH_B_GO:   begin lamp_a = LT_RED;    lamp_b = LT_GREEN;  end
            default:   begin lamp_a = LT_RED;    lamp_b = LT_YELLOW; end
        endcase
    end
endmodule

// File: rtl/xroad_light_ctrl.sv
// Top level: festival-mode flag machine driving the hold input of the phase
// sequencer, followed by the output decode. Assumes one clock domain and
// synchronous active-low reset.
module xroad_light_ctrl
    import xroad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sense_a,
    input  logic       sense_b,
    input  logic       fest_enter,
    input  logic       fest_leave,
    output logic [1:0] light_a,
    output logic [1:0] light_b,
    output logic       festival_on
);
    logic   fest_q;
    phase_t phase;
    light_t lamp_a, lamp_b;

    xroad_fest_mode u_mode (
        .clk(clk), .rst_n(rst_n),
        .enter_req(fest_enter), .leave_req(fest_leave),
        .active(fest_q)
    );

    xroad_sequencer u_seq (
        .clk(clk), .rst_n(rst_n),
        .busy_a(sense_a), .busy_b(sense_b), .hold_b(fest_q),
        .phase(phase)
    );

    xroad_light_decode u_dec (
        .phase(phase), .lamp_a(lamp_a), .lamp_b(lamp_b)
    );

    // Drive the output ports from the decoded lights and the flag.
    always_comb begin
        light_a     = lamp_a;
        light_b     = lamp_b;
        festival_on = fest_q;
    end

    a_r2_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
        light_a != 2'b11 && light_b != 2'b11);
    a_r9_one_road_open: assert property (@(posedge clk) disable iff (!rst_n)
        light_a == 2'b10 || light_b == 2'b10);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (light_a == 2'b00 && light_b == 2'b10 && !festival_on));
    a_r8_festival_holds_b: assert property (@(posedge clk) disable iff (!rst_n)
        (festival_on && light_b == 2'b00 && !fest_leave) |=> light_b == 2'b00);
endmodule

// File: tb/tb_xroad_light_ctrl.sv
module tb_xroad_light_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense_a = 1'b0, sense_b = 1'b0, fest_enter = 1'b0, fest_leave = 1'b0;
    logic [1:0] light_a, light_b;
    logic festival_on;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state: phase 0..3 and festival flag.
    int  m_ph   = 0;
    bit  m_fest = 1'b0;

    always #10 clk = ~clk;

    xroad_light_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sense_a(sense_a), .sense_b(sense_b),
        .fest_enter(fest_enter), .fest_leave(fest_leave),
        .light_a(light_a), .light_b(light_b), .festival_on(festival_on)
    );

    function automatic logic [1:0] exp_a(int p);
        case (p)
            0: return 2'b00;
            1: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [1:0] exp_b(int p);
        case (p)
            2: return 2'b00;
            3: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    // Reference model update at each rising edge (uses pre-edge inputs).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_fest = 1'b0;
        end else begin
            case (m_ph)
                0: if (!sense_a) m_ph = 1;
                1: m_ph = 2;
                2: if (!sense_b && !m_fest) m_ph = 3;
                default: m_ph = 0;
            endcase
            if (fest_leave) m_fest = 1'b0;
            else if (fest_enter) m_fest = 1'b1;
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            n_tests++;
            if (light_a !== exp_a(m_ph) || light_b !== exp_b(m_ph) ||
                festival_on !== m_fest) begin
                n_fail++;
                $display("FAIL R2/R9 per-cycle model: a=%b b=%b f=%b exp a=%b b=%b f=%b",
                         light_a, light_b, festival_on, exp_a(m_ph), exp_b(m_ph), m_fest);
            end
        end
    end

    task automatic check(string req, logic [1:0] ea, logic [1:0] eb, logic ef);
        n_tests++;
        if (light_a !== ea || light_b !== eb || festival_on !== ef) begin
            n_fail++;
            $display("FAIL %s: a=%b b=%b f=%b exp a=%b b=%b f=%b",
                     req, light_a, light_b, festival_on, ea, eb, ef);
        end
    endtask

    // Advance one clock and settle at the falling edge.
    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        // R1 reset state.
        check("R1", 2'b00, 2'b10, 1'b0);

        // R3: hold A green under traffic.
        sense_a = 1'b1; sense_b = 1'b1;
        step(3);
        check("R3 hold", 2'b00, 2'b10, 1'b0);
        sense_a = 1'b0;
        step(1);
        check("R3 leave", 2'b01, 2'b10, 1'b0);
        // R4: one yellow cycle then B green.
        step(1);
        check("R4", 2'b10, 2'b00, 1'b0);
        // R5: hold B green while sense_b.
        step(3);
        check("R5 hold", 2'b10, 2'b00, 1'b0);
        sense_b = 1'b0;
        step(1);
        check("R5 leave", 2'b10, 2'b01, 1'b0);
        // R6: B yellow one cycle then A green.
        step(1);
        check("R6", 2'b00, 2'b10, 1'b0);

        // R8: festival requested in A green; sequence travels to B green.
        fest_enter = 1'b1;
        step(1);
        fest_enter = 1'b0;
        check("R7 set", 2'b01, 2'b10, 1'b1);
        step(1);
        check("R8 reach", 2'b10, 2'b00, 1'b1);
        step(5);
        check("R8 hold", 2'b10, 2'b00, 1'b1);

        // R7: enter and leave together; leave wins.
        fest_enter = 1'b1; fest_leave = 1'b1;
        step(1);
        fest_enter = 1'b0; fest_leave = 1'b0;
        check("R7 priority", 2'b10, 2'b00, 1'b0);
        step(1);
        check("R5 release", 2'b10, 2'b01, 1'b0);

        // Leave while road B still busy: hold remains due to sensor.
        step(1);
        check("R6 wrap", 2'b00, 2'b10, 1'b0);
        step(2);
        fest_enter = 1'b1; sense_b = 1'b1;
        step(1);
        fest_enter = 1'b0;
        step(4);
        fest_leave = 1'b1;
        step(1);
        fest_leave = 1'b0;
        check("R7 clear", 2'b10, 2'b00, 1'b0);
        step(2);
        check("R5 sensor hold", 2'b10, 2'b00, 1'b0);
        sense_b = 1'b0;
        step(1);
        check("R5 sensor release", 2'b10, 2'b01, 1'b0);

        // R1: reset mid-sequence with flag set.
        fest_enter = 1'b1;
        step(1);
        fest_enter = 1'b0;
        rst_n = 1'b0;
        step(1);
        check("R1 mid reset", 2'b00, 2'b10, 1'b0);
        rst_n = 1'b1;
        step(4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule